// File: doc/BRIEF.md
# Picture Output Streaming Sequencer

This block moves decoded picture samples out of a frame buffer to display logic, one sample per handshake. It reads one word at a time from a frame buffer read port that has a fixed latency. It holds each word on its output until the consumer signals that the word is taken. Every sample carries a four-bit tag. The low half of the tag names the colour component and the high half names the scan structure: progressive, top field or bottom field.

The host configures the block through a small register write port. One register sets the row length in pixel groups. Another sets the number of rows, and a third drives a general-purpose output bus. The control register sets the sample width, the scan structure, whether end-of-row and end-of-picture markers are generated, and whether early terminations from the consumer are honoured. A start bit launches one picture.

In byte mode a pixel group is four samples: Cb, Y, Cr, Y. In word mode a group is two samples: Y with Cb, then Y with Cr. When the consumer asks for an early row or picture end, the block finishes the current group first, then moves to the next row or stops.

Top module: `pic_stream_seq`

## Requirements
- R1: After reset, px_valid, fb_rd_req, px_row_end_out, px_pic_end_out and px_general are all low.
- R2: px_valid is high only while a picture is running. It is low once the picture has ended. A start request is ignored while the row length or the row count is zero.
- R3: While px_valid is high and px_taken is low, px_valid and px_data hold their values into the next cycle. A sample is consumed at the rising edge where both px_valid and px_taken are high.
- R4: In byte mode (control bit 3 = 0), each group emits four samples whose px_type[1:0] codes are 10 (Cb), 00 (Y), 11 (Cr) and 01 (Y), in that order. px_data is the low byte of the frame word, zero-extended.
- R5: In word mode (control bit 3 = 1), each group emits two samples with px_type[1:0] codes 10, then 11. px_data is the full 16-bit frame word: Y in the upper byte, chroma in the lower byte.
- R6: px_type[3:2] equals the structure field written to control bits 5:4. A written code of 01 is emitted as 00, so 01 never appears on px_type[3:2].
- R7: When control bit 2 is set, px_row_end_out is high with the last sample of the last group of each row. It is low otherwise, and always low when bit 2 is clear.
- R8: When control bit 2 is set, px_pic_end_out is high with the last sample of the last group of the last row. It is low otherwise.
- R9: With control bit 1 set, px_row_end_in sampled together with px_taken on a valid sample makes the block finish the current group. The next sample is then the first of the next row, whose first frame address is the previous row start plus the row length times the samples per group.
- R10: With control bit 1 set, px_pic_end_in sampled together with px_taken on a valid sample makes the block finish the current group and then go idle.
- R11: px_row_end_in and px_pic_end_in have no effect when control bit 1 is clear, or in a cycle where px_taken is low or px_valid is low.
- R12: px_general reflects the value last written to register 3, from the cycle after the write.
- R13: Each emitted sample is preceded by exactly one single-cycle fb_rd_req. Its fb_rd_addr is the row start address plus the group index times the samples per group plus the sample index within the group, with the first row starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 control, 1 row length, 2 row count, 3 general |
| cfg_wdata | input | 16 | Register write data |
| fb_rd_req | output | 1 | Frame buffer read request, one cycle per sample |
| fb_rd_addr | output | 20 | Frame buffer read address |
| fb_rd_valid | input | 1 | Read data valid, fixed latency after the request |
| fb_rd_data | input | 16 | Read data |
| px_data | output | 16 | Sample presented to the display logic |
| px_valid | output | 1 | Sample on px_data is real |
| px_type | output | 4 | Structure code [3:2], component code [1:0] |
| px_taken | input | 1 | Consumer takes the sample at the next rising edge |
| px_row_end_in | input | 1 | Consumer request to end the row, qualified by px_taken |
| px_pic_end_in | input | 1 | Consumer request to end the picture, qualified by px_taken |
| px_row_end_out | output | 1 | Last sample of a row |
| px_pic_end_out | output | 1 | Last sample of the picture |
| px_general | output | 8 | Mirror of the general register |

## Verification
Whole pictures are streamed in both sample widths, with random taken strobes, so that held samples and consumed samples both appear. The bench predicts each sample's data, address-derived content, component code and markers. Some pictures raise the consumer done inputs at random with terminations disabled, and count full-length pictures to show the inputs are ignored. Directed pictures raise a row end on every take, or a picture end on the first take. These separate "finish the group, then jump to the next row address" from "finish the group, then stop". Further cases cover a one-group picture with both markers on the same sample, a start with a zero row length, and the 01 structure code.

// File: rtl/pos_pkg.sv
// Shared definitions for the picture output streaming sequencer.
// Assumes two-bit register addresses and at most four samples per group.
package pos_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_SHOW
    } seq_state_t;

    typedef struct packed {
        logic       ext_en;
        logic       gen_en;
        logic       wide;
        logic [1:0] structure;
    } ctrl_t;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_ROWLEN = 2'd1;
    localparam logic [1:0] REG_ROWS   = 2'd2;
    localparam logic [1:0] REG_GEN    = 2'd3;

    localparam int CTL_START  = 0;
    localparam int CTL_EXT    = 1;
    localparam int CTL_GEN    = 2;
    localparam int CTL_WIDE   = 3;
    localparam int CTL_STR_LO = 4;

    // Component code for a sample index within its group.
    function automatic logic [1:0] comp_code(input logic wide, input logic [1:0] idx);
        logic [1:0] code;
        if (wide) begin
            code = idx[0] ? 2'b11 : 2'b10;
        end else begin
            case (idx)
                2'd0:    code = 2'b10;
                2'd1:    code = 2'b00;
                2'd2:    code = 2'b11;
                default: code = 2'b01;
            endcase
        end
        return code;
    endfunction

endpackage

// File: rtl/pos_regs.sv
// Host register file: control fields, row length, row count and the
// general output register. Writing the control register with bit 0 set
// produces a one-cycle start pulse. Assumes CW >= LW, GW and 6.
module pos_regs #(
    parameter int CW = 16,
    parameter int LW = 16,
    parameter int GW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [CW-1:0]   cfg_wdata,
    output pos_pkg::ctrl_t  ctrl,
    output logic [LW-1:0]   row_groups,
    output logic [LW-1:0]   rows,
    output logic [GW-1:0]   gen_q,
    output logic            start_pulse
);
    import pos_pkg::*;

    logic [1:0] str_w;
    assign str_w = cfg_wdata[CTL_STR_LO +: 2];

    // Register writes and start pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl        <= '0;
            row_groups  <= '0;
            rows        <= '0;
            gen_q       <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[CTL_START];
            if (cfg_we) begin
                case (cfg_addr)
                    REG_CTRL: begin
                        ctrl.ext_en    <= cfg_wdata[CTL_EXT];
                        ctrl.gen_en    <= cfg_wdata[CTL_GEN];
                        ctrl.wide      <= cfg_wdata[CTL_WIDE];
                        ctrl.structure <= (str_w == 2'b01) ? 2'b00 : str_w;
                    end
                    REG_ROWLEN: row_groups <= cfg_wdata[LW-1:0];
                    REG_ROWS:   rows       <= cfg_wdata[LW-1:0];
                    default:    gen_q      <= cfg_wdata[GW-1:0];
                endcase
            end
        end
    end

    assert_gen_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_GEN) |=> (gen_q == $past(cfg_wdata[GW-1:0])));

endmodule

// File: rtl/pos_counters.sv
// Position counters: sample index in group, group in row, row in picture,
// row start address and read pointer. Assumes non-zero lengths while
// running; load clears all, step advances by one taken sample.
module pos_counters #(
    parameter int AW = 20,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          wide,
    input  logic [LW-1:0] row_groups,
    input  logic [LW-1:0] rows,
    input  logic          row_term,
    input  logic          pic_term,
    output logic [AW-1:0] ptr,
    output logic [1:0]    comp,
    output logic          last_comp,
    output logic          last_grp,
    output logic          last_row,
    output logic          finish
);
    localparam logic [LW-1:0] ONE_L = 1;
    localparam logic [AW-1:0] ONE_A = 1;

    logic [LW-1:0] grp;
    logic [LW-1:0] row;
    logic [AW-1:0] base;
    logic [AW-1:0] stride;
    logic          end_row;

    assign stride    = wide ? (AW'(row_groups) << 1) : (AW'(row_groups) << 2);
    assign last_comp = wide ? comp[0] : (comp == 2'd3);
    assign last_grp  = (grp == row_groups - ONE_L);
    assign last_row  = (row == rows - ONE_L);
    assign end_row   = last_grp || row_term;
    assign finish    = step && last_comp && (pic_term || (end_row && last_row));

    // Advance position on each taken sample, jumping rows on row end.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            comp <= '0;
            grp  <= '0;
            row  <= '0;
            base <= '0;
            ptr  <= '0;
        end else if (step) begin
            if (!last_comp) begin
                comp <= comp + 2'd1;
                ptr  <= ptr + ONE_A;
            end else if (end_row) begin
                comp <= '0;
                grp  <= '0;
                row  <= row + ONE_L;
                base <= base + stride;
                ptr  <= base + stride;
            end else begin
                comp <= '0;
                grp  <= grp + ONE_L;
                ptr  <= ptr + ONE_A;
            end
        end
    end

    assert_ptr_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !last_comp) |=> (ptr == $past(ptr) + ONE_A));

endmodule

// File: rtl/pic_stream_seq.sv
// Picture output streaming sequencer. Fetches one frame word per sample,
// presents it with a component and structure tag, and waits for the
// consumer's taken strobe. Consumer end requests are latched and applied
// at the end of the current pixel group. Assumes DW = 16 and a frame
// buffer that answers every request exactly once.
module pic_stream_seq #(
    parameter int DW = 16,
    parameter int AW = 20,
    parameter int LW = 16,
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [15:0]   cfg_wdata,
    output logic          fb_rd_req,
    output logic [AW-1:0] fb_rd_addr,
    input  logic          fb_rd_valid,
    input  logic [DW-1:0] fb_rd_data,
    output logic [DW-1:0] px_data,
    output logic          px_valid,
    output logic [3:0]    px_type,
    input  logic          px_taken,
    input  logic          px_row_end_in,
    input  logic          px_pic_end_in,
    output logic          px_row_end_out,
    output logic          px_pic_end_out,
    output logic [GW-1:0] px_general
);
    import pos_pkg::*;

    localparam int BW = DW / 2;
    localparam logic [LW-1:0] ZERO_L = '0;

    ctrl_t         ctrl;
    logic [LW-1:0] row_groups;
    logic [LW-1:0] rows;
    logic          start_pulse;
    seq_state_t    state;
    logic [DW-1:0] data_q;
    logic          row_pend;
    logic          pic_pend;
    logic          take;
    logic          launch;
    logic          row_req;
    logic          pic_req;
    logic [1:0]    comp;
    logic          last_comp;
    logic          last_grp;
    logic          last_row;
    logic          finish;

    pos_regs #(.CW(16), .LW(LW), .GW(GW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .ctrl        (ctrl),
        .row_groups  (row_groups),
        .rows        (rows),
        .gen_q       (px_general),
        .start_pulse (start_pulse)
    );

    assign take    = (state == ST_SHOW) && px_taken;
    assign launch  = (state == ST_IDLE) && start_pulse
                     && (row_groups != ZERO_L) && (rows != ZERO_L);
    assign row_req = ctrl.ext_en && take && px_row_end_in;
    assign pic_req = ctrl.ext_en && take && px_pic_end_in;

    pos_counters #(.AW(AW), .LW(LW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .step       (take),
        .wide       (ctrl.wide),
        .row_groups (row_groups),
        .rows       (rows),
        .row_term   (row_pend || row_req),
        .pic_term   (pic_pend || pic_req),
        .ptr        (fb_rd_addr),
        .comp       (comp),
        .last_comp  (last_comp),
        .last_grp   (last_grp),
        .last_row   (last_row),
        .finish     (finish)
    );

    // Sequence fetch, wait and show phases for each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (launch) state <= ST_FETCH;
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT:  if (fb_rd_valid) state <= ST_SHOW;
                default:  if (take) state <= finish ? ST_IDLE : ST_FETCH;
            endcase
        end
    end

    // Latch consumer end requests until the current group completes.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            row_pend <= 1'b0;
            pic_pend <= 1'b0;
        end else if (take && last_comp) begin
            row_pend <= 1'b0;
            pic_pend <= 1'b0;
        end else begin
            if (row_req) row_pend <= 1'b1;
            if (pic_req) pic_pend <= 1'b1;
        end
    end

    // Capture returned frame data, narrowing to one byte in byte mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state == ST_WAIT && fb_rd_valid) begin
            data_q <= ctrl.wide ? fb_rd_data : {{BW{1'b0}}, fb_rd_data[BW-1:0]};
        end
    end

    assign fb_rd_req      = (state == ST_FETCH);
    assign px_valid       = (state == ST_SHOW);
    assign px_data        = data_q;
    assign px_type        = {ctrl.structure, comp_code(ctrl.wide, comp)};
    assign px_row_end_out = px_valid && ctrl.gen_en && last_comp && last_grp;
    assign px_pic_end_out = px_row_end_out && last_row;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_taken) |=> (px_valid && $stable(px_data)));

    assert_no_odd_struct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (px_type[3:2] != 2'b01));

    assert_req_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_req |=> !fb_rd_req);

    assert_pic_in_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        px_pic_end_out |-> px_row_end_out);

    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && finish) |=> !px_valid);

endmodule

// File: tb/tb_pic_stream_seq.sv
// Self-checking bench: frame buffer model with fixed latency, random
// consumer handshake, and a behavioural model of the expected stream.
module tb_pic_stream_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        fb_rd_req;
    logic [19:0] fb_rd_addr;
    logic        fb_rd_valid;
    logic [15:0] fb_rd_data;
    logic [15:0] px_data;
    logic        px_valid;
    logic [3:0]  px_type;
    logic        px_taken = 1'b0;
    logic        px_row_end_in = 1'b0;
    logic        px_pic_end_in = 1'b0;
    logic        px_row_end_out;
    logic        px_pic_end_out;
    logic [7:0]  px_general;

    int n_tests = 0;
    int n_fail  = 0;
    int req_cnt = 0;
    int dummy;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_stream_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .fb_rd_req(fb_rd_req), .fb_rd_addr(fb_rd_addr),
        .fb_rd_valid(fb_rd_valid), .fb_rd_data(fb_rd_data),
        .px_data(px_data), .px_valid(px_valid), .px_type(px_type),
        .px_taken(px_taken), .px_row_end_in(px_row_end_in),
        .px_pic_end_in(px_pic_end_in), .px_row_end_out(px_row_end_out),
        .px_pic_end_out(px_pic_end_out), .px_general(px_general)
    );

    function automatic logic [15:0] fb_word(input logic [19:0] a);
        return (a[15:0] * 16'd37) ^ 16'hC35A ^ {12'h0, a[19:16]};
    endfunction

    // Frame buffer model: two-cycle latency, data derived from address.
    logic        v1, v2;
    logic [19:0] a1, a2;
    always @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; a1 <= '0; a2 <= '0;
        end else begin
            v1 <= fb_rd_req; a1 <= fb_rd_addr;
            v2 <= v1;        a2 <= a1;
            if (fb_rd_req) req_cnt <= req_cnt + 1;
        end
    end
    assign fb_rd_valid = v2;
    assign fb_rd_data  = fb_word(a2);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [1:0] exp_code(input bit wide, input int idx);
        if (wide) return (idx == 1) ? 2'b11 : 2'b10;
        case (idx)
            0: return 2'b10;
            1: return 2'b00;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    // Stream one picture and check every consumed sample against the model.
    task automatic run_pic(input bit wide, input bit ext, input bit gen, input logic [1:0] strv,
                           input int rg, input int nr, input int p_take, input int p_row,
                           input int p_pic, output int nsamp);
        int cpg = wide ? 2 : 4;
        int m_comp = 0, m_grp = 0, m_row = 0, m_base = 0;
        bit m_rp = 0, m_pp = 0, done = 0;
        bit pv = 0, pt = 0;
        logic [15:0] pd = '0;
        logic [1:0] es = (strv == 2'b01) ? 2'b00 : strv;
        int req0;
        nsamp = 0;
        cfg_write(2'd1, 16'(rg));
        cfg_write(2'd2, 16'(nr));
        req0 = req_cnt;
        cfg_write(2'd0, {10'b0, strv, wide, gen, ext, 1'b1});
        px_taken = 0; px_row_end_in = 0; px_pic_end_in = 0;
        while (!done) begin
            bit tk, ri, pi, lastc, endrow;
            int addr;
            logic [15:0] w, ed;
            @(negedge clk);
            if (pv && !pt)  // R3: held sample unchanged
                chk(px_valid && px_data == pd, "R3 hold", {15'b0, px_valid, px_data}, {16'h1, pd});
            tk = ($urandom % 100) < p_take;
            ri = ($urandom % 100) < p_row;
            pi = ($urandom % 100) < p_pic;
            if (px_valid && tk) begin
                addr = m_base + m_grp * cpg + m_comp;
                w = fb_word(20'(addr));
                ed = wide ? w : {8'h00, w[7:0]};
                lastc = (m_comp == cpg - 1);
                chk(px_data == ed, wide ? "R5 data" : "R4 data / R13 addr", px_data, ed);
                chk(px_type == {es, exp_code(wide, m_comp)}, wide ? "R5 R6 type" : "R4 R6 type",
                    px_type, {es, exp_code(wide, m_comp)});
                chk(px_row_end_out == (gen && lastc && m_grp == rg - 1), "R7 row marker",
                    px_row_end_out, gen && lastc && m_grp == rg - 1);
                chk(px_pic_end_out == (gen && lastc && m_grp == rg - 1 && m_row == nr - 1),
                    "R8 picture marker", px_pic_end_out,
                    gen && lastc && m_grp == rg - 1 && m_row == nr - 1);
                nsamp++;
                if (ext && ri) m_rp = 1;
                if (ext && pi) m_pp = 1;
                if (!lastc) begin
                    m_comp++;
                end else begin
                    m_comp = 0;
                    endrow = (m_grp == rg - 1) || m_rp;
                    if (m_pp || (endrow && m_row == nr - 1)) done = 1;
                    if (endrow) begin
                        m_grp = 0; m_row++; m_base += rg * cpg;
                    end else begin
                        m_grp++;
                    end
                    m_rp = 0; m_pp = 0;
                end
            end
            pv = px_valid; pt = tk; pd = px_data;
            px_taken = tk; px_row_end_in = ri; px_pic_end_in = pi;
        end
        @(negedge clk);
        px_taken = 0; px_row_end_in = 0; px_pic_end_in = 0;
        chk(!px_valid, "R2 idle after picture", px_valid, 0);
        @(negedge clk);
        chk(!px_valid, "R2 stays idle", px_valid, 0);
        chk(req_cnt - req0 == nsamp, "R13 one request per sample", req_cnt - req0, nsamp);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int ns;
        dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!px_valid && !fb_rd_req && !px_row_end_out && !px_pic_end_out && px_general == 0,
            "R1 reset state", {px_valid, fb_rd_req, px_row_end_out, px_pic_end_out, px_general}, 0);

        // R12: general register mirror
        cfg_write(2'd3, 16'h00A7);
        chk(px_general == 8'hA7, "R12 general", px_general, 8'hA7);
        cfg_write(2'd3, 16'h003C);
        chk(px_general == 8'h3C, "R12 general rewrite", px_general, 8'h3C);

        // R2: start ignored with zero row length
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd2, 16'd2);
        cfg_write(2'd0, 16'h0005);
        begin
            bit seen = 0;
            repeat (12) begin
                @(negedge clk);
                if (px_valid || fb_rd_req) seen = 1;
            end
            chk(!seen, "R2 zero length start ignored", seen, 0);
        end

        // R11: done inputs ignored with terminations disabled, byte mode
        run_pic(0, 0, 1, 2'b10, 3, 2, 60, 30, 30, ns);
        chk(ns == 24, "R11 full picture byte mode", ns, 24);
        // R11 / R6 / R7: word mode, markers off, structure 01 emitted as 00
        run_pic(1, 0, 0, 2'b01, 5, 3, 50, 20, 20, ns);
        chk(ns == 30, "R11 full picture word mode", ns, 30);
        // R9: row end on every take, rows jump after one group
        run_pic(0, 1, 1, 2'b11, 4, 3, 100, 100, 0, ns);
        chk(ns == 12, "R9 row termination count", ns, 12);
        // R10: picture end on first take stops after one group
        run_pic(1, 1, 1, 2'b00, 4, 4, 100, 0, 100, ns);
        chk(ns == 2, "R10 picture termination count", ns, 2);
        // R7 R8: single group picture, both markers on last word
        run_pic(1, 0, 1, 2'b10, 1, 1, 70, 0, 0, ns);
        chk(ns == 2, "R8 single group picture", ns, 2);
        // Random pictures with terminations enabled (R9 R10 R11)
        for (int i = 0; i < 6; i++) begin
            run_pic(1'($urandom % 2), 1, 1'($urandom % 2), 2'($urandom % 4),
                    1 + int'($urandom % 6), 1 + int'($urandom % 4),
                    40 + int'($urandom % 50), 10, 3, ns);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule